// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits between a CPU core with a 16-bit address bus and an 8-bit data path and the targets that share that bus. For each cycle it decides which target the CPU is reaching. The possible targets are the on-block 2 KB work RAM, an eight-entry video register file, the cartridge space, the two game-pad registers, the audio frame register, and the DMA trigger register. The decoder raises that target's read or write strobe and steers the returned byte back to the CPU. Address mirroring is applied on the way: the low 8 KB folds onto 2 KB of RAM, and the next 8 KB folds onto eight video registers.

Read data returns one cycle after the read is issued, for every target. The decoder registers the chosen read source so that it lines up with the RAM's registered output. External targets are expected to answer in the cycle that follows their read strobe. Read and write decode differ in the I/O page. A read of either game-pad address returns pad data. A write to the first pad address strobes the pad port, a write to the second reaches the audio unit instead, and a write to the DMA address reaches only the DMA trigger. Unmapped reads return zero, and unmapped writes are dropped.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A CPU address in 0x0000..0x1FFF selects the work RAM at index address[10:0]. The four 2 KB mirrors therefore reach the same byte, and a byte written through one mirror is read back through any other.
- R2: A CPU address in 0x2000..0x3FFF raises `vid_rd` (on a read) or `vid_wr` (on a write), with `vid_idx` = address[2:0]. A read returns `vid_rdata` one cycle later.
- R3: A CPU address in 0x8000..0xFFFF raises `cart_rd` or `cart_wr`, with `cart_addr` equal to the full CPU address. A read returns `cart_rdata` one cycle later.
- R4: A read of 0x4016 or 0x4017 raises `pad_rd`, with `pad_port` = address[0] (0 for 0x4016, 1 for 0x4017). The read returns `pad_rdata` one cycle later.
- R5: A write to 0x4016 raises `pad_wr` and no other strobe. A write to 0x4017 raises `apu_wr` and no other strobe.
- R6: A write to 0x4014 raises only `dma_wr`. No other strobe rises, and the RAM byte at index 0x014 keeps its value.
- R7: A read of an unmapped address (0x4000..0x4015, and 0x4018..0x7FFF) raises no strobe and returns 0x00 one cycle later.
- R8: A write to an unmapped address (any address in 0x4000..0x7FFF other than 0x4014, 0x4016 and 0x4017) raises no strobe and leaves the RAM unchanged.
- R9: `cpu_rdata` carries the byte for a read issued in the previous cycle. It is 0x00 in any cycle whose previous cycle issued no read.
- R10: When `cpu_rd` and `cpu_wr` are both high, the write is performed and no read strobe rises. The following cycle's `cpu_rdata` is 0x00.
- R11: While `rst_n` is low and in the first cycle after it, `cpu_rdata` is 0x00. With `cpu_rd` and `cpu_wr` low, all strobes are low.
- R12: At most one target strobe (RAM, video, cartridge, pad, audio, DMA) is high in any cycle. `tgt_wdata` equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| tgt_wdata | output | 8 | Write data toward all targets |
| vid_rd | output | 1 | Video register read strobe |
| vid_wr | output | 1 | Video register write strobe |
| vid_idx | output | 3 | Video register index |
| vid_rdata | input | 8 | Video register return data |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_addr | output | 16 | Cartridge address |
| cart_rdata | input | 8 | Cartridge return data |
| pad_rd | output | 1 | Game-pad read strobe |
| pad_wr | output | 1 | Game-pad write strobe |
| pad_port | output | 1 | Game-pad register select |
| pad_rdata | input | 8 | Game-pad return data |
| apu_wr | output | 1 | Audio frame register write strobe |
| dma_wr | output | 1 | DMA trigger write strobe |

## Verification
The bench builds the decoder with its default parameters: 16-bit address, 8-bit data, 2 KB RAM (11 index bits) and 3 video index bits. With these values the RAM mirror boundaries at 0x0800, 0x1000 and 0x1800 and the video fold every eight bytes are reachable at real addresses. The I/O page addresses sit where the decode asymmetries between reads and writes show. The behavioural model tracks RAM contents in a plain array and derives each target's answer from the strobe it saw. This lets a write through one mirror be checked against a read through another, and lets a DMA or unmapped write that aliases a RAM index be seen not to disturb it.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_RAM  = 3'd1,
    RS_VID  = 3'd2,
    RS_CART = 3'd3,
    RS_PAD  = 3'd4
  } rd_src_e;

  typedef enum logic [2:0] {
    WD_NONE = 3'd0,
    WD_RAM  = 3'd1,
    WD_VID  = 3'd2,
    WD_CART = 3'd3,
    WD_PAD  = 3'd4,
    WD_APU  = 3'd5,
    WD_DMA  = 3'd6
  } wr_dst_e;

  // Region tests shared by the read and write decode.
  function automatic logic in_ram(input logic [15:0] a);
    return a[15:13] == 3'b000;
  endfunction

  function automatic logic in_vid(input logic [15:0] a);
    return a[15:13] == 3'b001;
  endfunction

  function automatic logic in_cart(input logic [15:0] a);
    return a[15];
  endfunction

  function automatic rd_src_e read_target(input logic [15:0] a,
                                          input logic [15:0] pad0,
                                          input logic [15:0] pad1);
    if (in_ram(a))                   return RS_RAM;
    else if (in_vid(a))              return RS_VID;
    else if (in_cart(a))             return RS_CART;
    else if (a == pad0 || a == pad1) return RS_PAD;
    else                             return RS_NONE;
  endfunction

  function automatic wr_dst_e write_target(input logic [15:0] a,
                                           input logic [15:0] dma,
                                           input logic [15:0] pad0,
                                           input logic [15:0] apu);
    if (in_ram(a))       return WD_RAM;
    else if (in_vid(a))  return WD_VID;
    else if (in_cart(a)) return WD_CART;
    else if (a == dma)   return WD_DMA;
    else if (a == pad0)  return WD_PAD;
    else if (a == apu)   return WD_APU;
    else                 return WD_NONE;
  endfunction

endpackage

// File: rtl/cbd_addr_map.sv
module cbd_addr_map
  import cbd_pkg::*;
#(
  parameter logic [15:0] DMA_ADDR  = 16'h4014,
  parameter logic [15:0] PAD0_ADDR = 16'h4016,
  parameter logic [15:0] PAD1_ADDR = 16'h4017
) (
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  output rd_src_e     rsel,
  output wr_dst_e     wsel
);
  // A write wins when both requests are high.
  logic rd_only;
  assign rd_only = rd & ~wr;

  always_comb begin
    rsel = RS_NONE;
    wsel = WD_NONE;
    if (rd_only) rsel = read_target(addr, PAD0_ADDR, PAD1_ADDR);
    if (wr)      wsel = write_target(addr, DMA_ADDR, PAD0_ADDR, PAD1_ADDR);
  end
endmodule

// File: rtl/cbd_work_ram.sv
module cbd_work_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/cbd_rdata_mux.sv
module cbd_rdata_mux
  import cbd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_src_e       rsel,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] vid_q,
  input  logic [DW-1:0] cart_q,
  input  logic [DW-1:0] pad_q,
  output rd_src_e       sel_q,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= RS_NONE;
    else        sel_q <= rsel;
  end

  always_comb begin
    unique case (sel_q)
      RS_RAM:  rdata = ram_q;
      RS_VID:  rdata = vid_q;
      RS_CART: rdata = cart_q;
      RS_PAD:  rdata = pad_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import cbd_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          RAM_AW    = 11,
  parameter int          VID_AW    = 3,
  parameter logic [15:0] DMA_ADDR  = 16'h4014,
  parameter logic [15:0] PAD0_ADDR = 16'h4016,
  parameter logic [15:0] PAD1_ADDR = 16'h4017
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DW-1:0]     cpu_rdata,
  output logic [DW-1:0]     tgt_wdata,
  output logic              vid_rd,
  output logic              vid_wr,
  output logic [VID_AW-1:0] vid_idx,
  input  logic [DW-1:0]     vid_rdata,
  output logic              cart_rd,
  output logic              cart_wr,
  output logic [AW-1:0]     cart_addr,
  input  logic [DW-1:0]     cart_rdata,
  output logic              pad_rd,
  output logic              pad_wr,
  output logic              pad_port,
  input  logic [DW-1:0]     pad_rdata,
  output logic              apu_wr,
  output logic              dma_wr
);
  rd_src_e           rsel;
  wr_dst_e           wsel;
  rd_src_e           rsel_q;
  logic              ram_we;
  logic              ram_re;
  logic [DW-1:0]     ram_q;
  logic [RAM_AW-1:0] ram_idx;

  cbd_addr_map #(
    .DMA_ADDR (DMA_ADDR),
    .PAD0_ADDR(PAD0_ADDR),
    .PAD1_ADDR(PAD1_ADDR)
  ) u_map (
    .addr(cpu_addr),
    .rd  (cpu_rd),
    .wr  (cpu_wr),
    .rsel(rsel),
    .wsel(wsel)
  );

  // Mirroring: only the low index bits reach RAM and video registers.
  assign ram_idx = cpu_addr[RAM_AW-1:0];
  assign ram_we  = (wsel == WD_RAM);
  assign ram_re  = (rsel == RS_RAM);

  cbd_work_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .idx  (ram_idx),
    .wdata(cpu_wdata),
    .rdata(ram_q)
  );

  cbd_rdata_mux #(.DW(DW)) u_mux (
    .clk   (clk),
    .rst_n (rst_n),
    .rsel  (rsel),
    .ram_q (ram_q),
    .vid_q (vid_rdata),
    .cart_q(cart_rdata),
    .pad_q (pad_rdata),
    .sel_q (rsel_q),
    .rdata (cpu_rdata)
  );

  assign tgt_wdata = cpu_wdata;
  assign vid_idx   = cpu_addr[VID_AW-1:0];
  assign cart_addr = cpu_addr;
  assign pad_port  = cpu_addr[0];

  assign vid_rd  = (rsel == RS_VID);
  assign vid_wr  = (wsel == WD_VID);
  assign cart_rd = (rsel == RS_CART);
  assign cart_wr = (wsel == WD_CART);
  assign pad_rd  = (rsel == RS_PAD);
  assign pad_wr  = (wsel == WD_PAD);
  assign apu_wr  = (wsel == WD_APU);
  assign dma_wr  = (wsel == WD_DMA);
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic        vid_rd,
  input logic        vid_wr,
  input logic        cart_rd,
  input logic        cart_wr,
  input logic        pad_rd,
  input logic        pad_wr,
  input logic        apu_wr,
  input logic        dma_wr,
  input logic        ram_we,
  input logic        ram_re
);
  assert_vid_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_rd || vid_wr) |-> (cpu_addr >= 16'h2000 && cpu_addr <= 16'h3FFF));

  assert_cart_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_rd || cart_wr) |-> cpu_addr[15]);

  assert_dma_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr |-> (!ram_we && !vid_wr && !cart_wr && !pad_wr && !apu_wr));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr >= 16'h4018 && cpu_addr <= 16'h7FFF)
      |=> (cpu_rdata == 8'h00));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> (cpu_rdata == 8'h00));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_wr) |-> (!ram_re && !vid_rd && !cart_rd && !pad_rd));

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_we, ram_re, vid_rd, vid_wr, cart_rd, cart_wr,
                pad_rd, pad_wr, apu_wr, dma_wr}) <= 1);
endmodule

bind cpu_bus_decoder cbd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_rd   (cpu_rd),
  .cpu_wr   (cpu_wr),
  .cpu_rdata(cpu_rdata),
  .vid_rd   (vid_rd),
  .vid_wr   (vid_wr),
  .cart_rd  (cart_rd),
  .cart_wr  (cart_wr),
  .pad_rd   (pad_rd),
  .pad_wr   (pad_wr),
  .apu_wr   (apu_wr),
  .dma_wr   (dma_wr),
  .ram_we   (ram_we),
  .ram_re   (ram_re)
);

// File: tb/cpu_bus_decoder_tb.sv
module cpu_bus_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, tgt_wdata;
  logic        vid_rd, vid_wr, cart_rd, cart_wr, pad_rd, pad_wr, pad_port, apu_wr, dma_wr;
  logic [2:0]  vid_idx;
  logic [15:0] cart_addr;
  logic [7:0]  vid_rdata = '0, cart_rdata = '0, pad_rdata = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] ram_m [2048];
  int   exp_next = 0;
  string tag_next = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_bus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .tgt_wdata(tgt_wdata),
    .vid_rd(vid_rd), .vid_wr(vid_wr), .vid_idx(vid_idx), .vid_rdata(vid_rdata),
    .cart_rd(cart_rd), .cart_wr(cart_wr), .cart_addr(cart_addr), .cart_rdata(cart_rdata),
    .pad_rd(pad_rd), .pad_wr(pad_wr), .pad_port(pad_port), .pad_rdata(pad_rdata),
    .apu_wr(apu_wr), .dma_wr(dma_wr)
  );

  // Target models: each answers in the cycle after its read strobe.
  always @(posedge clk) begin
    vid_rdata  <= 8'hA0 | {5'd0, vid_idx};
    cart_rdata <= cart_addr[7:0] ^ cart_addr[15:8];
    pad_rdata  <= {7'h20, pad_port};
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: check last cycle's read data, drive, check strobes.
  task automatic access(input string tag, input bit rd, input bit wr,
                        input int addr, input int data);
    int rt, wt, exp_rd;
    @(negedge clk);
    chk({tag_next, " rdata"}, cpu_rdata, exp_next);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = addr[15:0]; cpu_wdata = data[7:0];
    // target codes: 0 none, 1 ram, 2 vid, 3 cart, 4 pad, 5 apu, 6 dma
    rt = 0; wt = 0;
    if (addr < 'h2000) begin rt = 1; wt = 1; end
    else if (addr < 'h4000) begin rt = 2; wt = 2; end
    else if (addr >= 'h8000) begin rt = 3; wt = 3; end
    else begin
      if (addr == 'h4016 || addr == 'h4017) rt = 4;
      if (addr == 'h4016) wt = 4;
      if (addr == 'h4017) wt = 5;
      if (addr == 'h4014) wt = 6;
    end
    if (!rd || wr) rt = 0;
    if (!wr) wt = 0;
    exp_rd = 0;
    case (rt)
      1: exp_rd = ram_m[addr & 'h7FF];
      2: exp_rd = 'hA0 | (addr & 7);
      3: exp_rd = (addr & 'hFF) ^ ((addr >> 8) & 'hFF);
      4: exp_rd = 'h40 | (addr & 1);
      default: exp_rd = 0;
    endcase
    if (wt == 1) ram_m[addr & 'h7FF] = data[7:0];
    #1;
    chk({tag, " vid_rd"},  vid_rd,  rt == 2);
    chk({tag, " vid_wr"},  vid_wr,  wt == 2);
    chk({tag, " cart_rd"}, cart_rd, rt == 3);
    chk({tag, " cart_wr"}, cart_wr, wt == 3);
    chk({tag, " pad_rd"},  pad_rd,  rt == 4);
    chk({tag, " pad_wr"},  pad_wr,  wt == 4);
    chk({tag, " apu_wr"},  apu_wr,  wt == 5);
    chk({tag, " dma_wr"},  dma_wr,  wt == 6);
    if (rt == 2 || wt == 2) chk({tag, " vid_idx"}, vid_idx, addr & 7);
    if (rt == 3 || wt == 3) chk({tag, " cart_addr"}, cart_addr, addr);
    if (rt == 4) chk({tag, " pad_port"}, pad_port, addr & 1);
    if (wr) chk("R12 tgt_wdata", tgt_wdata, data & 'hFF);
    exp_next = exp_rd;
    tag_next = tag;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset rdata", cpu_rdata, 0);
    chk("R11 reset strobes", {vid_rd, vid_wr, cart_rd, cart_wr, pad_rd, pad_wr, apu_wr, dma_wr}, 0);
    rst_n = 1'b1;
    access("R11 idle", 0, 0, 'h0000, 0);
    access("R9 idle", 0, 0, 'h0000, 0);
    // R1 RAM mirrors
    access("R1 wr", 0, 1, 'h0005, 'h5A);
    access("R1 rd m1", 1, 0, 'h0805, 0);
    access("R1 rd m3", 1, 0, 'h1805, 0);
    access("R1 wr top", 0, 1, 'h1FFF, 'hC3);
    access("R1 rd base", 1, 0, 'h07FF, 0);
    access("R9 idle", 0, 0, 'h0000, 0);
    // R2 video
    access("R2 rd", 1, 0, 'h2000, 0);
    access("R2 rd", 1, 0, 'h2007, 0);
    access("R2 rd fold", 1, 0, 'h3FFE, 0);
    access("R2 wr", 0, 1, 'h3009, 'h77);
    // R3 cartridge
    access("R3 rd", 1, 0, 'h8000, 0);
    access("R3 rd", 1, 0, 'hFFFF, 0);
    access("R3 rd", 1, 0, 'hC15A, 0);
    access("R3 wr", 0, 1, 'hC123, 'h42);
    // R4/R5 pad and audio
    access("R4 rd pad0", 1, 0, 'h4016, 0);
    access("R4 rd pad1", 1, 0, 'h4017, 0);
    access("R5 wr pad", 0, 1, 'h4016, 'h01);
    access("R5 wr apu", 0, 1, 'h4017, 'h40);
    // R6 DMA trigger does not touch RAM index 0x014
    access("R6 pre", 0, 1, 'h0014, 'h11);
    access("R6 dma", 0, 1, 'h4014, 'h99);
    access("R6 after", 1, 0, 'h0014, 0);
    // R7 unmapped reads
    access("R7 rd", 1, 0, 'h4000, 0);
    access("R7 rd", 1, 0, 'h4014, 0);
    access("R7 rd", 1, 0, 'h4015, 0);
    access("R7 rd", 1, 0, 'h4018, 0);
    access("R7 rd", 1, 0, 'h5000, 0);
    access("R7 rd", 1, 0, 'h7FFF, 0);
    // R8 unmapped writes leave RAM
    access("R8 wr", 0, 1, 'h6014, 'hEE);
    access("R8 wr", 0, 1, 'h4015, 'hEE);
    access("R8 chk", 1, 0, 'h1014, 0);
    // R10 read and write together
    access("R10 both", 1, 1, 'h2003, 'h12);
    access("R10 both ram", 1, 1, 'h0100, 'h34);
    access("R10 readback", 1, 0, 'h0900, 0);
    access("R9 idle", 0, 0, 'h0000, 0);
    access("R9 idle", 0, 0, 'h0000, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule